// File: doc/BRIEF.md
# Guest Interrupt Priority and Control Registers

This block holds the registers a hypervisor uses to steer interrupts seen by a guest running at supervisor level. It has two parts. The first is one control word, and one bit of that word turns guest accesses to the supervisor interrupt-enable and interrupt-pending registers into traps. The second is a table of 8-bit priorities indexed by interrupt number. Software reaches the table through priority registers that pack several priority bytes into one register word. The number of bytes per word follows the current register width: 4 bytes in 32-bit mode and 8 in 64-bit mode. Some slots of a priority word always read as zero. Others have no interrupt behind them and are skipped.

The block sits beside a larger CSR file and answers in the cycle of the request. A read returns data and a fault code combinationally. A write that does not fault commits at the next rising clock edge. Three inputs qualify every access: the register-width mode, a flag for virtualized execution and an enable for the interrupt-architecture extension. The block decides whether the access completes, raises an illegal-instruction fault or raises a virtual-instruction fault. The block also decodes the addresses of the supervisor interrupt-enable and interrupt-pending registers, but only to raise the trap. Those two registers live elsewhere in the CSR file, so for every other access to them this block answers with no fault and zero data.

Top module: `vgi_prio_regs`

## Requirements
- R1: After reset, the control word reads as 0 and every priority slot reads as 0.
- R2: A write to the control word (address 0x609) stores only the bits covered by mask 0x4FFF_0300 (bits 30, 27:16, 9, 8). A read returns the stored value. In 32-bit mode, bits 63:32 of the write data are ignored.
- R3: In 64-bit mode, address 0x646 carries slots 0..7 and address 0x647 carries slots 8..15. Slot base+i occupies read/write data bits 8i+7:8i.
- R4: In 32-bit mode, four slots are packed per word: 0x646 carries slots 0..3, 0x656 slots 4..7, 0x647 slots 8..11 and 0x657 slots 12..15. Read data bits 63:32 are zero, and write data bits 63:32 are ignored.
- R5: Slot 0 always reads 0. A write to slot 0 stores 0, whatever the write data.
- R6: Slots 2, 3, 4 and 6 have no interrupt behind them. They read 0, and writes to them change nothing.
- R7: Slots 1 and 5 are bound to interrupts 1 and 5, and slots 7..15 to interrupts 13..21. A slot holds the same stored byte in both width modes and keeps it until it is written again.
- R8: An access whose first slot is not a multiple of the slots per word faults: 0x656 and 0x657 in 64-bit mode. The fault code is 2 (virtual-instruction) when virtualized and 1 (illegal-instruction) otherwise. Read data is 0 and no state changes.
- R9: With the extension disabled, any access to the control word or to a priority register faults with code 1 and changes no state, even when virtualized.
- R10: When virtualized and control bit 30 is set, an access to 0x104 (supervisor interrupt-enable) or 0x144 (supervisor interrupt-pending) returns fault code 2. Otherwise these addresses return fault 0 and read data 0.
- R11: With no read and no write requested, or with an address that the block does not own, the fault code is 0 and read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | Register address of the access |
| csr_re | input | 1 | Read request |
| csr_we | input | 1 | Write request |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, valid in the request cycle |
| csr_fault | output | 2 | 0 none, 1 illegal-instruction, 2 virtual-instruction |
| wide_mode | input | 1 | 1 selects 64-bit register width, 0 selects 32-bit |
| virt_on | input | 1 | Guest (virtualized) execution is active |
| ext_en | input | 1 | Interrupt-architecture extension enabled |

## Verification
The bench builds the block with its default parameters: 64-bit maximum register width, 8-bit priorities, a 64-entry table, control bit 30 as the trap bit and the standard register addresses. These values allow both width modes to be used at run time. The bench can then write a slot through a 64-bit word and read it back as a 32-bit word. They also make the two high-half priority registers legal in one mode and misaligned in the other, so the same address is seen both completing and faulting.

// File: rtl/vgi_pkg.sv
package vgi_pkg;

   // fault codes returned with every access
   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_ILLEGAL = 2'd1,
      FLT_VIRT    = 2'd2
   } fault_e;

   // what a priority-word slot stands for
   typedef struct packed {
      logic       bound;   // an interrupt sits behind the slot
      logic       zeroed;  // slot always reads zero, writes store zero
      logic [5:0] irq;     // interrupt number (table index)
   } slot_bind_t;

   // slot number -> interrupt binding
   function automatic slot_bind_t slot_bind(input logic [5:0] slot);
      slot_bind_t b;
      b.bound  = 1'b1;
      b.zeroed = 1'b0;
      b.irq    = slot;
      if (slot == 6'd0) begin
         b.zeroed = 1'b1;
      end else if (slot == 6'd1 || slot == 6'd5) begin
         b.irq = slot;
      end else if (slot >= 6'd7 && slot <= 6'd15) begin
         b.irq = slot + 6'd6;
      end else begin
         b.bound = 1'b0;
         b.irq   = '0;
      end
      return b;
   endfunction

endpackage

// File: rtl/vgi_access_chk.sv
module vgi_access_chk
   import vgi_pkg::*;
#(
   parameter int              ADDR_W     = 12,
   parameter int              LANES_WIDE = 8,
   parameter logic [ADDR_W-1:0] A_CTL    = 12'h609,
   parameter logic [ADDR_W-1:0] A_PW0    = 12'h646,
   parameter logic [ADDR_W-1:0] A_PW0_HI = 12'h656,
   parameter logic [ADDR_W-1:0] A_PW1    = 12'h647,
   parameter logic [ADDR_W-1:0] A_PW1_HI = 12'h657,
   parameter logic [ADDR_W-1:0] A_S_IE   = 12'h104,
   parameter logic [ADDR_W-1:0] A_S_IP   = 12'h144
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic              re,
   input  logic              we,
   input  logic              wide_mode,
   input  logic              virt_on,
   input  logic              ext_en,
   input  logic              trap_bit,
   output logic              sel_ctl,
   output logic              sel_prio,
   output logic [5:0]        first_slot,
   output fault_e            fault,
   output logic              commit_ctl,
   output logic              commit_prio,
   output logic              rd_ok
);

   localparam logic [5:0] MASK_WIDE   = 6'(LANES_WIDE - 1);
   localparam logic [5:0] MASK_NARROW = 6'(LANES_WIDE / 2 - 1);

   generate
      if (LANES_WIDE < 2 || (LANES_WIDE & (LANES_WIDE - 1)) != 0)
         $error("vgi_access_chk: LANES_WIDE must be a power of two >= 2");
   endgenerate

   logic access;
   logic misaligned;
   logic sel_trap;

   // address decode, first slot of each priority word
   always_comb begin
      sel_ctl    = (addr == A_CTL);
      sel_prio   = 1'b1;
      first_slot = 6'd0;
      if (addr == A_PW0)         first_slot = 6'd0;
      else if (addr == A_PW0_HI) first_slot = 6'd4;
      else if (addr == A_PW1)    first_slot = 6'd8;
      else if (addr == A_PW1_HI) first_slot = 6'd12;
      else                       sel_prio   = 1'b0;
   end

   assign sel_trap   = (addr == A_S_IE) || (addr == A_S_IP);
   assign access     = re || we;
   assign misaligned = ((first_slot & (wide_mode ? MASK_WIDE : MASK_NARROW)) != 6'd0);

   always_comb begin
      fault = FLT_NONE;
      if (access) begin
         if (sel_ctl || sel_prio) begin
            if (!ext_en)
               fault = FLT_ILLEGAL;
            else if (sel_prio && misaligned)
               fault = virt_on ? FLT_VIRT : FLT_ILLEGAL;
         end else if (sel_trap && virt_on && trap_bit) begin
            fault = FLT_VIRT;
         end
      end
   end

   assign commit_ctl  = we && sel_ctl  && (fault == FLT_NONE);
   assign commit_prio = we && sel_prio && (fault == FLT_NONE);
   assign rd_ok       = re && (fault == FLT_NONE);

endmodule

// File: rtl/vgi_ctl_reg.sv
module vgi_ctl_reg #(
   parameter int             W    = 64,
   parameter logic [W-1:0]   MASK = 64'h0000_0000_4FFF_0300
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] ctl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctl_q <= '0;
      else if (we) ctl_q <= wdata & MASK;
   end

   AST_CTL_INSIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q & ~MASK) == '0); // R2

endmodule

// File: rtl/vgi_prio_table.sv
module vgi_prio_table
   import vgi_pkg::*;
#(
   parameter int NUM_PRIO = 64,
   parameter int PRIO_W   = 8,
   parameter int LANES    = 8
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wide_mode,
   input  logic [5:0]                 first_slot,
   input  logic                       we,
   input  logic [LANES*PRIO_W-1:0]    wdata,
   output logic [LANES*PRIO_W-1:0]    rdata,
   output logic [NUM_PRIO*PRIO_W-1:0] prio_flat
);

   localparam int IDX_W = $clog2(NUM_PRIO);

   generate
      if (NUM_PRIO < 22 || NUM_PRIO > 64)
         $error("vgi_prio_table: NUM_PRIO must cover interrupts 0..21 and fit 6 bits");
      if (LANES < 2 || (LANES % 2) != 0)
         $error("vgi_prio_table: LANES must be even");
   endgenerate

   logic [PRIO_W-1:0] tbl [NUM_PRIO];
   slot_bind_t        lane_bind [LANES];
   logic [LANES-1:0]  lane_on;

   // per-lane decode and read byte
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_bind[l] = slot_bind(first_slot + 6'(l));
      if (l < LANES / 2) begin : g_low
         assign lane_on[l] = 1'b1;
      end else begin : g_high
         assign lane_on[l] = wide_mode;
      end
      assign rdata[l*PRIO_W +: PRIO_W] =
         (lane_on[l] && lane_bind[l].bound && !lane_bind[l].zeroed)
            ? tbl[IDX_W'(lane_bind[l].irq)] : '0;
   end

   // per-entry storage, written by whichever lane binds to it
   for (genvar e = 0; e < NUM_PRIO; e++) begin : g_ent
      logic              hit;
      logic [PRIO_W-1:0] nxt;

      always_comb begin
         hit = 1'b0;
         nxt = '0;
         for (int l = 0; l < LANES; l++) begin
            if (we && lane_on[l] && lane_bind[l].bound && lane_bind[l].irq == 6'(e)) begin
               hit = 1'b1;
               nxt = lane_bind[l].zeroed ? '0 : wdata[l*PRIO_W +: PRIO_W];
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   tbl[e] <= '0;
         else if (hit) tbl[e] <= nxt;
      end

      assign prio_flat[e*PRIO_W +: PRIO_W] = tbl[e];
   end

   AST_ZERO_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      tbl[0] == '0); // R5

   AST_UNBOUND_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      tbl[2] == '0 && tbl[3] == '0 && tbl[4] == '0); // R6

   AST_READ_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      first_slot == 6'd0 |-> rdata[PRIO_W-1:0] == '0); // R5

endmodule

// File: rtl/vgi_prio_regs.sv
module vgi_prio_regs
   import vgi_pkg::*;
#(
   parameter int                ADDR_W   = 12,
   parameter int                XLEN_MAX = 64,
   parameter int                PRIO_W   = 8,
   parameter int                NUM_PRIO = 64,
   parameter int                TRAP_BIT = 30,
   parameter logic [63:0]       CTL_MASK = 64'h0000_0000_4FFF_0300,
   parameter logic [ADDR_W-1:0] A_CTL    = 12'h609,
   parameter logic [ADDR_W-1:0] A_PW0    = 12'h646,
   parameter logic [ADDR_W-1:0] A_PW0_HI = 12'h656,
   parameter logic [ADDR_W-1:0] A_PW1    = 12'h647,
   parameter logic [ADDR_W-1:0] A_PW1_HI = 12'h657,
   parameter logic [ADDR_W-1:0] A_S_IE   = 12'h104,
   parameter logic [ADDR_W-1:0] A_S_IP   = 12'h144
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   csr_addr,
   input  logic                csr_re,
   input  logic                csr_we,
   input  logic [XLEN_MAX-1:0] csr_wdata,
   output logic [XLEN_MAX-1:0] csr_rdata,
   output logic [1:0]          csr_fault,
   input  logic                wide_mode,
   input  logic                virt_on,
   input  logic                ext_en
);

   localparam int LANES = XLEN_MAX / PRIO_W;
   localparam int HALF  = XLEN_MAX / 2;

   generate
      if (XLEN_MAX != 64)
         $error("vgi_prio_regs: XLEN_MAX must be 64");
      if (PRIO_W * 4 != 32)
         $error("vgi_prio_regs: four priorities per 32 bits requires PRIO_W == 8");
      if (TRAP_BIT < 0 || TRAP_BIT >= HALF)
         $error("vgi_prio_regs: TRAP_BIT must lie in the low half");
      if (CTL_MASK[TRAP_BIT] != 1'b1)
         $error("vgi_prio_regs: CTL_MASK must keep the trap bit");
      if (CTL_MASK[63:HALF] != '0)
         $error("vgi_prio_regs: CTL_MASK must fit the narrow width");
   endgenerate

   logic                       sel_ctl, sel_prio;
   logic [5:0]                 first_slot;
   fault_e                     fault;
   logic                       commit_ctl, commit_prio, rd_ok;
   logic [XLEN_MAX-1:0]        ctl_q;
   logic [XLEN_MAX-1:0]        wdata_eff;
   logic [XLEN_MAX-1:0]        prio_rd;
   logic [XLEN_MAX-1:0]        rd_raw;
   logic [NUM_PRIO*PRIO_W-1:0] prio_flat;

   // narrow mode: upper half of the write data never reaches storage
   assign wdata_eff = wide_mode ? csr_wdata : {{HALF{1'b0}}, csr_wdata[HALF-1:0]};

   vgi_access_chk #(
      .ADDR_W     (ADDR_W),
      .LANES_WIDE (LANES),
      .A_CTL      (A_CTL),
      .A_PW0      (A_PW0),
      .A_PW0_HI   (A_PW0_HI),
      .A_PW1      (A_PW1),
      .A_PW1_HI   (A_PW1_HI),
      .A_S_IE     (A_S_IE),
      .A_S_IP     (A_S_IP)
   ) chk_i (
      .addr        (csr_addr),
      .re          (csr_re),
      .we          (csr_we),
      .wide_mode   (wide_mode),
      .virt_on     (virt_on),
      .ext_en      (ext_en),
      .trap_bit    (ctl_q[TRAP_BIT]),
      .sel_ctl     (sel_ctl),
      .sel_prio    (sel_prio),
      .first_slot  (first_slot),
      .fault       (fault),
      .commit_ctl  (commit_ctl),
      .commit_prio (commit_prio),
      .rd_ok       (rd_ok)
   );

   vgi_ctl_reg #(
      .W    (XLEN_MAX),
      .MASK (CTL_MASK[XLEN_MAX-1:0])
   ) ctl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit_ctl),
      .wdata (wdata_eff),
      .ctl_q (ctl_q)
   );

   vgi_prio_table #(
      .NUM_PRIO (NUM_PRIO),
      .PRIO_W   (PRIO_W),
      .LANES    (LANES)
   ) tbl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wide_mode  (wide_mode),
      .first_slot (first_slot),
      .we         (commit_prio),
      .wdata      (wdata_eff),
      .rdata      (prio_rd),
      .prio_flat  (prio_flat)
   );

   always_comb begin
      rd_raw = '0;
      if (sel_ctl)       rd_raw = ctl_q;
      else if (sel_prio) rd_raw = prio_rd;
      if (!wide_mode)    rd_raw[XLEN_MAX-1:HALF] = '0;
   end

   assign csr_rdata = rd_ok ? rd_raw : '0;
   assign csr_fault = fault;

   AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      csr_fault != 2'd0 |=> $stable(ctl_q) && $stable(prio_flat)); // R8

   AST_EXT_OFF_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_re || csr_we) && !ext_en && (csr_addr == A_CTL || csr_addr == A_PW0 || csr_addr == A_PW1)
         |-> csr_fault == 2'd1); // R9

   AST_TRAP_ON_GUEST_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_re || csr_we) && virt_on && ctl_q[TRAP_BIT] && (csr_addr == A_S_IE || csr_addr == A_S_IP)
         |-> csr_fault == 2'd2); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(csr_re || csr_we) |-> csr_fault == 2'd0 && csr_rdata == '0); // R11

   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_mode |-> csr_rdata[XLEN_MAX-1:HALF] == '0); // R4

   AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      csr_fault != 2'd3); // R11

endmodule

// File: tb/vgi_prio_regs_tb.sv
module vgi_prio_regs_tb_top;

   localparam logic [11:0] A_CTL = 12'h609;
   localparam logic [11:0] A_P0  = 12'h646;
   localparam logic [11:0] A_P0H = 12'h656;
   localparam logic [11:0] A_P1  = 12'h647;
   localparam logic [11:0] A_P1H = 12'h657;
   localparam logic [11:0] A_SIE = 12'h104;
   localparam logic [11:0] A_SIP = 12'h144;
   localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;

   typedef struct packed {
      logic        wide;
      logic        virt;
      logic        ext;
      logic        re;
      logic        we;
      logic [11:0] addr;
      logic [63:0] wdata;
      logic [63:0] exp_rd;
      logic [1:0]  exp_flt;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 30;
   // wide virt ext re we addr wdata exp_rd exp_flt req
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_CTL,64'h0,64'h0,2'd0,8'd1},                                   // R1
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_P0 ,64'h0,64'h0,2'd0,8'd1},                                   // R1
      '{1'b1,1'b0,1'b1,1'b0,1'b1,A_CTL,ONES,64'h0,2'd0,8'd2},                                    // R2
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_CTL,64'h0,64'h0000_0000_4FFF_0300,2'd0,8'd2},                 // R2
      '{1'b1,1'b0,1'b1,1'b0,1'b1,A_P0 ,64'h8877_6655_4433_2211,64'h0,2'd0,8'd3},                 // R3
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_P0 ,64'h0,64'h8800_6600_0000_2200,2'd0,8'd6},                 // R6 R5 R3
      '{1'b1,1'b0,1'b1,1'b0,1'b1,A_P1 ,64'hF0E0_D0C0_B0A0_9080,64'h0,2'd0,8'd3},                 // R3
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_P1 ,64'h0,64'hF0E0_D0C0_B0A0_9080,2'd0,8'd3},                 // R3
      '{1'b0,1'b0,1'b1,1'b1,1'b0,A_P0 ,64'h0,64'h0000_0000_0000_2200,2'd0,8'd7},                 // R7
      '{1'b0,1'b0,1'b1,1'b1,1'b0,A_P0H,64'h0,64'h0000_0000_8800_6600,2'd0,8'd4},                 // R4
      '{1'b0,1'b0,1'b1,1'b0,1'b1,A_P1H,64'hDEAD_BEEF_1234_5678,64'h0,2'd0,8'd4},                 // R4
      '{1'b0,1'b0,1'b1,1'b1,1'b0,A_P1H,64'h0,64'h0000_0000_1234_5678,2'd0,8'd4},                 // R4
      '{1'b0,1'b0,1'b1,1'b1,1'b0,A_P1 ,64'h0,64'h0000_0000_B0A0_9080,2'd0,8'd4},                 // R4
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_P1 ,64'h0,64'h1234_5678_B0A0_9080,2'd0,8'd7},                 // R7
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_P0H,64'h0,64'h0,2'd1,8'd8},                                   // R8
      '{1'b1,1'b1,1'b1,1'b0,1'b1,A_P1H,ONES,64'h0,2'd2,8'd8},                                    // R8
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_P1 ,64'h0,64'h1234_5678_B0A0_9080,2'd0,8'd8},                 // R8
      '{1'b1,1'b0,1'b0,1'b0,1'b1,A_CTL,64'h0,64'h0,2'd1,8'd9},                                   // R9
      '{1'b1,1'b1,1'b0,1'b1,1'b0,A_P0 ,64'h0,64'h0,2'd1,8'd9},                                   // R9
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_CTL,64'h0,64'h0000_0000_4FFF_0300,2'd0,8'd9},                 // R9
      '{1'b1,1'b1,1'b1,1'b1,1'b0,A_SIE,64'h0,64'h0,2'd2,8'd10},                                  // R10
      '{1'b1,1'b1,1'b1,1'b0,1'b1,A_SIP,ONES,64'h0,2'd2,8'd10},                                   // R10
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_SIE,64'h0,64'h0,2'd0,8'd10},                                  // R10
      '{1'b1,1'b0,1'b1,1'b0,1'b1,A_CTL,64'h0000_0000_0000_0300,64'h0,2'd0,8'd2},                 // R2
      '{1'b1,1'b1,1'b1,1'b1,1'b0,A_SIE,64'h0,64'h0,2'd0,8'd10},                                  // R10
      '{1'b1,1'b0,1'b1,1'b0,1'b0,A_P1 ,ONES,64'h0,2'd0,8'd11},                                   // R11
      '{1'b1,1'b0,1'b1,1'b1,1'b0,12'h300,64'h0,64'h0,2'd0,8'd11},                                // R11
      '{1'b0,1'b0,1'b1,1'b0,1'b1,A_P0 ,64'h0000_0000_AABB_CCDD,64'h0,2'd0,8'd5},                 // R5
      '{1'b1,1'b0,1'b1,1'b1,1'b0,A_P0 ,64'h0,64'h8800_6600_0000_CC00,2'd0,8'd5},                 // R5
      '{1'b0,1'b0,1'b1,1'b1,1'b0,A_CTL,64'h0,64'h0000_0000_0000_0300,2'd0,8'd2}                  // R2
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic        csr_re = 1'b0;
   logic        csr_we = 1'b0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] csr_rdata;
   logic [1:0]  csr_fault;
   logic        wide_mode = 1'b1;
   logic        virt_on = 1'b0;
   logic        ext_en = 1'b1;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   vgi_prio_regs dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_addr  (csr_addr),
      .csr_re    (csr_re),
      .csr_we    (csr_we),
      .csr_wdata (csr_wdata),
      .csr_rdata (csr_rdata),
      .csr_fault (csr_fault),
      .wide_mode (wide_mode),
      .virt_on   (virt_on),
      .ext_en    (ext_en)
   );

   // drive after the falling edge, compare before the next rising edge
   task automatic apply(input vec_t v);
      @(negedge clk);
      wide_mode = v.wide;
      virt_on   = v.virt;
      ext_en    = v.ext;
      csr_re    = v.re;
      csr_we    = v.we;
      csr_addr  = v.addr;
      csr_wdata = v.wdata;
      #2;
      n_checks++;
      if (csr_rdata !== v.exp_rd || csr_fault !== v.exp_flt) begin
         n_fail++;
         $display("FAIL R%0d addr=%h rdata=%h fault=%0d expected rdata=%h fault=%0d",
                  v.req, v.addr, csr_rdata, csr_fault, v.exp_rd, v.exp_flt);
      end
   endtask

   function automatic vec_t mk(input logic wide, input logic re, input logic we,
                               input logic [11:0] addr, input logic [63:0] wd,
                               input logic [63:0] er, input logic [7:0] req);
      vec_t v;
      v = '{wide, 1'b0, 1'b1, re, we, addr, wd, er, 2'd0, req};
      return v;
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) apply(VECS[i]);

      // R2: narrow write with all-ones data keeps only masked low bits
      apply(mk(1'b0, 1'b0, 1'b1, A_CTL, ONES, 64'h0, 8'd2));
      apply(mk(1'b1, 1'b1, 1'b0, A_CTL, 64'h0, 64'h0000_0000_4FFF_0300, 8'd2));

      // R7: write slots while virtualized (aligned, no fault) and read back
      begin
         vec_t v;
         v = mk(1'b0, 1'b0, 1'b1, A_P0H, 64'h0, 64'h0, 8'd7);
         v.virt = 1'b1;
         v.wdata = 64'h0000_0000_5544_3322;
         apply(v);
      end
      apply(mk(1'b1, 1'b1, 1'b0, A_P0, 64'h0, 64'h5500_3300_0000_CC00, 8'd7));

      // R1: reset in the middle of a run clears everything
      @(negedge clk);
      csr_re = 1'b0;
      csr_we = 1'b0;
      rst_n  = 1'b0;
      @(negedge clk);
      rst_n  = 1'b1;
      apply(mk(1'b1, 1'b1, 1'b0, A_CTL, 64'h0, 64'h0, 8'd1));
      apply(mk(1'b1, 1'b1, 1'b0, A_P1, 64'h0, 64'h0, 8'd1));
      apply(mk(1'b1, 1'b1, 1'b0, A_P0, 64'h0, 64'h0, 8'd1));
      apply(mk(1'b0, 1'b1, 1'b0, A_P1H, 64'h0, 64'h0, 8'd1));

      @(negedge clk);
      csr_re = 1'b0;
      csr_we = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule